// File: doc/BRIEF.md
# Enabled Eight-Bit Shift-Register Pseudo-Random Source

This block is a clocked eight-bit linear feedback shift register that serves as a cheap pseudo-random source. On each clock edge where stepping is enabled, the register moves one place toward its least significant bit. A fresh bit enters at the top. That bit is the exclusive-OR of four fixed taps: state bits 0, 2, 3 and 4. The whole register value is presented as a parallel word. Its top bit is also presented as a serial stream.

A synchronous reset returns the register to the value 0x01, never to zero, because an all-zero register would stay at zero for good. A load strobe can replace the state with an eight-bit seed in a single cycle. A seed of zero is replaced by 0x01 for the same reason. Reset takes priority over load, and load takes priority over stepping. When none of the three applies, the state is held.

Internally, a small control module turns the three inputs into a one-hot group of strobes: clear, load and advance. A datapath module owns the register and the feedback network. A thin top module joins the two.

Top module: `prng_lfsr8`

## Requirements
- R1: When `rst` is high at a rising clock edge, the state becomes 0x01 after that edge.
- R2: With `rst` and `seedLoad` low and `stepEn` high, the next state is {f, s[7:1]}, where s is the current state and f = s[4] ^ s[3] ^ s[2] ^ s[0].
- R3: With `rst`, `seedLoad` and `stepEn` all low, the state is unchanged across the edge, whatever `seedIn` carries.
- R4: With `rst` low and `seedLoad` high, a nonzero `seedIn` becomes the next state, whatever the level of `stepEn`.
- R5: With `rst` low and `seedLoad` high, a `seedIn` of 0x00 loads 0x01 instead.
- R6: Reset wins over load and over stepping; load wins over stepping.
- R7: `serialOut` always equals bit 7 of `stateOut`.
- R8: Once reset has been applied, the state is never 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, forces state 0x01 |
| stepEn | input | 1 | Advances the register by one place when high |
| seedLoad | input | 1 | Replaces the state with the seed when high |
| seedIn | input | 8 | Seed value; zero is mapped to 0x01 |
| stateOut | output | 8 | Current register value |
| serialOut | output | 1 | Top bit of the register |

## Verification
The properties take for granted that `rst` is held high over the first clock edge. They also assume that every control input is a clean 0 or 1 at each edge, because the no-zero rule and the stepping rule are only meaningful once the register holds a known value. The stimulus raises reset from time zero. It then changes inputs only on falling edges with fully defined values. It sweeps all 256 seed values, with the enable level alternating underneath the load strobe. It runs long stepping stretches in which the state is compared with an arithmetic model and checked for zero.

// File: rtl/prng_lfsr8_pkg.sv
package prng_lfsr8_pkg;
  localparam int STATE_W = 8;
  localparam logic [STATE_W-1:0] TAP_MASK = 8'b0001_1101;
  localparam logic [STATE_W-1:0] SAFE_VALUE = 8'h01;

  typedef struct packed {
    logic clear;
    logic load;
    logic advance;
  } ctrlStrobes_t;
endpackage

// File: rtl/prng_lfsr8_ctrl.sv
module prng_lfsr8_ctrl
  import prng_lfsr8_pkg::*;
(
  input  logic         rst,
  input  logic         stepEn,
  input  logic         seedLoad,
  output ctrlStrobes_t strobes
);
  // Fixed priority: clear, then load, then advance. At most one strobe is high.
  always_comb begin
    strobes = '0;
    if (rst) begin
      strobes.clear = 1'b1;
    end else if (seedLoad) begin
      strobes.load = 1'b1;
    end else if (stepEn) begin
      strobes.advance = 1'b1;
    end
  end
endmodule

// File: rtl/prng_lfsr8_dp.sv
module prng_lfsr8_dp
  import prng_lfsr8_pkg::*;
#(
  parameter int WIDTH = STATE_W,
  parameter logic [WIDTH-1:0] TAPS = TAP_MASK,
  parameter logic [WIDTH-1:0] SAFE = SAFE_VALUE
) (
  input  logic             clk,
  input  ctrlStrobes_t     strobes,
  input  logic [WIDTH-1:0] seedIn,
  output logic [WIDTH-1:0] stateQ
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] tapTerms;
  logic             feedbackBit;
  logic [WIDTH-1:0] seedSafe;
  logic [WIDTH-1:0] shiftedState;
  logic [WIDTH-1:0] stateNext;

  // Keep only the tapped bits; their XOR is the feedback bit.
  for (genvar i = 0; i < WIDTH; i++) begin : g_tap
    if (TAPS[i]) begin : g_on
      assign tapTerms[i] = stateQ[i];
    end else begin : g_off
      assign tapTerms[i] = 1'b0;
    end
  end

  assign feedbackBit  = ^tapTerms;
  assign shiftedState = {feedbackBit, stateQ[TOP:1]};
  assign seedSafe     = (seedIn == '0) ? SAFE : seedIn;

  always_comb begin
    stateNext = stateQ;
    if (strobes.clear) begin
      stateNext = SAFE;
    end else if (strobes.load) begin
      stateNext = seedSafe;
    end else if (strobes.advance) begin
      stateNext = shiftedState;
    end
  end

  always_ff @(posedge clk) begin
    stateQ <= stateNext;
  end
endmodule

// File: rtl/prng_lfsr8.sv
module prng_lfsr8
  import prng_lfsr8_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               stepEn,
  input  logic               seedLoad,
  input  logic [STATE_W-1:0] seedIn,
  output logic [STATE_W-1:0] stateOut,
  output logic               serialOut
);
  ctrlStrobes_t     strobes;
  logic [STATE_W-1:0] stateQ;

  prng_lfsr8_ctrl u_ctrl (
    .rst      (rst),
    .stepEn   (stepEn),
    .seedLoad (seedLoad),
    .strobes  (strobes)
  );

  prng_lfsr8_dp #(
    .WIDTH (STATE_W),
    .TAPS  (TAP_MASK),
    .SAFE  (SAFE_VALUE)
  ) u_dp (
    .clk     (clk),
    .strobes (strobes),
    .seedIn  (seedIn),
    .stateQ  (stateQ)
  );

  assign stateOut  = stateQ;
  assign serialOut = stateQ[STATE_W-1];
endmodule

// File: rtl/prng_lfsr8_chk.sv
module prng_lfsr8_chk (
  input logic       clk,
  input logic       rst,
  input logic       stepEn,
  input logic       seedLoad,
  input logic [7:0] seedIn,
  input logic [7:0] stateOut,
  input logic       serialOut
);
  // R1 and R6: reset beats every other input.
  a_r1_reset_value: assert property (@(posedge clk) rst |=> stateOut == 8'h01);

  // R2: stepping follows the shift-and-feedback rule.
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (!seedLoad && stepEn) |=> stateOut == {$past(stateOut[4]) ^ $past(stateOut[3]) ^
                                           $past(stateOut[2]) ^ $past(stateOut[0]),
                                           $past(stateOut[7:1])});

  // R3: the state holds when nothing is requested.
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!seedLoad && !stepEn) |=> $stable(stateOut));

  // R4: a nonzero seed loads verbatim, even with stepping requested.
  a_r4_load: assert property (@(posedge clk) disable iff (rst)
    (seedLoad && seedIn != 8'h00) |=> stateOut == $past(seedIn));

  // R5: a zero seed is replaced.
  a_r5_zero_seed: assert property (@(posedge clk) disable iff (rst)
    (seedLoad && seedIn == 8'h00) |=> stateOut == 8'h01);

  // R7: the serial bit tracks the top state bit.
  a_r7_serial: assert property (@(posedge clk) disable iff (rst)
    serialOut == stateOut[7]);

  // R8: after any reset-free cycle the state is nonzero.
  a_r8_nonzero: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> stateOut != 8'h00);
endmodule

bind prng_lfsr8 prng_lfsr8_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .stepEn    (stepEn),
  .seedLoad  (seedLoad),
  .seedIn    (seedIn),
  .stateOut  (stateOut),
  .serialOut (serialOut)
);

// File: tb/prng_lfsr8_bench.sv
module prng_lfsr8_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stepEn = 1'b0;
  logic       seedLoad = 1'b0;
  logic [7:0] seedIn = 8'h00;
  logic [7:0] stateOut;
  logic       serialOut;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  logic [7:0] model = 8'h01;

  always #(CLK_PERIOD / 2) clk = ~clk;

  prng_lfsr8 u_prng_lfsr8 (
    .clk       (clk),
    .rst       (rst),
    .stepEn    (stepEn),
    .seedLoad  (seedLoad),
    .seedIn    (seedIn),
    .stateOut  (stateOut),
    .serialOut (serialOut)
  );

  function automatic logic [7:0] modelNext(input logic [7:0] s, input logic r,
                                           input logic e, input logic l,
                                           input logic [7:0] sd);
    if (r) return 8'h01;
    if (l) return (sd == 8'h00) ? 8'h01 : sd;
    if (e) return {s[4] ^ s[3] ^ s[2] ^ s[0], s[7:1]};
    return s;
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic r, input logic e, input logic l,
                       input logic [7:0] sd, input string req);
    @(negedge clk);
    rst = r; stepEn = e; seedLoad = l; seedIn = sd;
    @(posedge clk);
    #1;
    model = modelNext(model, r, e, l, sd);
    check(stateOut, model, req);
    check({7'd0, serialOut}, {7'd0, stateOut[7]}, "R7");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cycle(1'b1, 1'b0, 1'b0, 8'h00, "R1");
    cycle(1'b1, 1'b1, 1'b0, 8'h00, "R1");

    // R2 and R8: long run of stepping
    for (int i = 0; i < 600; i++) begin
      cycle(1'b0, 1'b1, 1'b0, 8'(i * 37), "R2");
      if (stateOut == 8'h00) check(stateOut, 8'h01, "R8");
    end

    // R3: hold with a varying seed bus and load low
    for (int i = 0; i < 40; i++) begin
      cycle(1'b0, 1'b0, 1'b0, 8'(i * 11 + 3), "R3");
    end

    // R2 and R3: enable toggling
    for (int i = 0; i < 200; i++) begin
      cycle(1'b0, 1'(i[0] ^ i[2]), 1'b0, 8'hA5, "R2_R3");
      if (stateOut == 8'h00) check(stateOut, 8'h01, "R8");
    end

    // R4 and R5: every seed, with enable alternating under the load, then one step
    for (int s = 0; s < 256; s++) begin
      cycle(1'b0, 1'(s[0]), 1'b1, 8'(s), (s == 0) ? "R5" : "R4");
      cycle(1'b0, 1'b1, 1'b0, 8'h00, "R2");
    end

    // R6: reset beats load and enable; load beats enable
    cycle(1'b0, 1'b0, 1'b1, 8'h5C, "R4");
    cycle(1'b1, 1'b1, 1'b1, 8'hF0, "R6");
    cycle(1'b0, 1'b1, 1'b1, 8'h80, "R6");
    cycle(1'b0, 1'b1, 1'b1, 8'h00, "R6");
    cycle(1'b0, 1'b1, 1'b0, 8'h00, "R2");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule